// File: doc/BRIEF.md
# Self-Repair Sequencer with Redundancy Remap

This block sits between a small word-oriented RAM and the rest of the chip. The top `SPARES` words of the RAM are ordinary storage. The block can also hold them back as replacements for faulty words in the lower, normal range. After a synchronous active-low reset, raising the test-mode input starts a march test over the normal addresses only. Every failing address goes into a small fault store, and an address that fails again is recorded only once. The test engine and the fault store work side by side in both test passes.

When the first pass ends, the sequencer takes one of two paths. It stops at once if no word failed or if the failures outnumbered the spares. Otherwise it runs the march test a second time, with every recorded address steered to its own spare word. A done flag and a two-bit result code then hold until the next reset.

In access mode the RAM is driven from the system port. With repair enabled, recorded addresses are redirected to their spares and the spare range cannot be written. With repair disabled, every word is reached directly.

Top module: `selfrepair_top`

## Requirements
- R1: During and after reset with test mode low, `done` is 0 and `result` is 2'b00.
- R2: Raising `test_mode` after reset starts the first test pass, and during that pass the RAM address stays below NORMAL (DEPTH-SPARES).
- R3: A RAM with no faulty normal word finishes with `done`=1 and `result`=2'b00 (clean), with no second pass.
- R4: When 1 to SPARES distinct normal words fail, a second pass runs with those words remapped. If it sees no failure, `result`=2'b10 (repaired).
- R5: When more than SPARES distinct normal words fail, the block finishes with `result`=2'b01 (not repairable).
- R6: If any read fails during the second pass, for example because a spare word is itself faulty, `result`=2'b11 (repair failed).
- R7: A word that fails in several march elements takes one fault-store entry, so SPARES stuck-at-0 words, each failing twice, still give 2'b10.
- R8: In access mode with `repair_en`=1, a recorded address reads back what was written to it. The data lives in the spare word given by the order of discovery: first fault goes to word NORMAL, second to NORMAL+1, and so on.
- R9: In access mode with `repair_en`=0, all DEPTH words are reached directly. A faulty word shows its fault, and a spare word holds written data.
- R10: In access mode with `repair_en`=1, a write to an address at or above NORMAL does not reach the RAM.
- R11: Once `done` is 1, `done` and `result` stay unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| test_mode | input | 1 | 1: RAM driven by the test engine; 0: access mode |
| repair_en | input | 1 | Access-mode remap enable (spares hidden) |
| sys_addr | input | AW | System address |
| sys_we | input | 1 | System write enable |
| sys_wdata | input | DW | System write data |
| sys_rdata | output | DW | System read data |
| ram_addr | output | AW | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data (combinational read) |
| done | output | 1 | Flow finished |
| result | output | 2 | 00 clean, 01 not repairable, 10 repaired, 11 repair failed |

## Verification
Two events can land on the same clock edge: the test engine's last read and the decision that ends a pass. If a fault is stored, or a retest failure is flagged, on that very edge, the decision could miss it. The bench provokes this by placing stuck words at the last tested address. It also uses words that fail in two march elements, so recording and deduplication meet in the same pass. It judges the outcome by the final result code and by the data read back through the remapped system port.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_TEST   = 2'd1,
        PH_RETEST = 2'd2,
        PH_DONE   = 2'd3
    } phase_t;

    localparam logic [1:0] RES_CLEAN  = 2'b00;
    localparam logic [1:0] RES_OVFL   = 2'b01;
    localparam logic [1:0] RES_PASS   = 2'b10;
    localparam logic [1:0] RES_FAIL   = 2'b11;

    localparam int NUM_ELEM = 6;

    typedef struct packed {
        logic rd;
        logic val;
    } march_op_t;

    // element 0: write 0; 1..4: read then write; 5: read 0
    function automatic logic elem_two_ops(input logic [2:0] e);
        return (e != 3'd0) && (e != 3'd5);
    endfunction

    function automatic logic elem_down(input logic [2:0] e);
        return (e == 3'd3) || (e == 3'd4);
    endfunction

    function automatic march_op_t march_op(input logic [2:0] e, input logic i);
        march_op_t o;
        o.rd = (i == 1'b0) && (e != 3'd0);
        case (e)
            3'd1, 3'd3: o.val = i;
            3'd2, 3'd4: o.val = ~i;
            default:    o.val = 1'b0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/sr_march_engine.sv
module sr_march_engine
    import srp_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 32,
    parameter int NORMAL = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic          we,
    output logic [DW-1:0] wdata,
    output logic          fail,
    output logic          done
);
    localparam logic [AW-1:0] LAST = AW'(NORMAL - 1);

    logic       busy;
    logic [2:0] elem;
    logic       opi;
    march_op_t  op;
    logic       last_op;
    logic       at_end;

    assign op      = march_op(elem, opi);
    assign last_op = elem_two_ops(elem) ? opi : 1'b1;
    assign at_end  = elem_down(elem) ? (addr == '0) : (addr == LAST);

    assign we    = busy && !op.rd;
    assign wdata = {DW{op.val}};
    assign fail  = busy && op.rd && (rdata != {DW{op.val}});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            elem <= '0;
            opi  <= 1'b0;
            addr <= '0;
        end else if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            elem <= '0;
            opi  <= 1'b0;
            addr <= '0;
        end else if (busy) begin
            if (!last_op) begin
                opi <= 1'b1;
            end else begin
                opi <= 1'b0;
                if (at_end) begin
                    if (elem == 3'(NUM_ELEM - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        elem <= elem + 3'd1;
                        addr <= elem_down(elem + 3'd1) ? LAST : '0;
                    end
                end else begin
                    addr <= elem_down(elem) ? addr - 1'b1 : addr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sr_fault_store.sv
module sr_fault_store #(
    parameter int AW     = 6,
    parameter int SPARES = 4,
    parameter int NORMAL = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rec_en,
    input  logic [AW-1:0] rec_addr,
    input  logic [AW-1:0] a_addr,
    output logic          a_hit,
    output logic [AW-1:0] a_spare,
    input  logic [AW-1:0] b_addr,
    output logic          b_hit,
    output logic [AW-1:0] b_spare,
    output logic          any_fault,
    output logic          overflow
);
    localparam int CW = $clog2(SPARES + 1);

    logic [AW-1:0]     ent_addr [SPARES];
    logic [SPARES-1:0] ent_vld;
    logic [CW-1:0]     count;
    logic [SPARES-1:0] rec_m, a_m, b_m;

    for (genvar g = 0; g < SPARES; g++) begin : g_cmp
        assign rec_m[g] = ent_vld[g] && (ent_addr[g] == rec_addr);
        assign a_m[g]   = ent_vld[g] && (ent_addr[g] == a_addr);
        assign b_m[g]   = ent_vld[g] && (ent_addr[g] == b_addr);
    end

    always_comb begin
        a_spare = '0;
        b_spare = '0;
        for (int k = SPARES - 1; k >= 0; k--) begin
            if (a_m[k]) a_spare = AW'(NORMAL + k);
            if (b_m[k]) b_spare = AW'(NORMAL + k);
        end
    end

    assign a_hit     = |a_m;
    assign b_hit     = |b_m;
    assign any_fault = (count != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ent_vld  <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else if (rec_en && !(|rec_m)) begin
            if (count == CW'(SPARES)) begin
                overflow <= 1'b1;
            end else begin
                for (int k = 0; k < SPARES; k++) begin
                    if (CW'(k) == count) begin
                        ent_addr[k] <= rec_addr;
                        ent_vld[k]  <= 1'b1;
                    end
                end
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sr_ram_model.sv
module sr_ram_model #(
    parameter int AW = 6,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DEPTH-1:0] sa0_mask,
    input  logic [DEPTH-1:0] sa1_mask,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    always_comb begin
        if (sa0_mask[addr])      rdata = '0;
        else if (sa1_mask[addr]) rdata = '1;
        else                     rdata = mem[addr];
    end

endmodule

// File: rtl/selfrepair_top.sv
module selfrepair_top
    import srp_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 32,
    parameter int SPARES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    input  logic          repair_en,
    input  logic [AW-1:0] sys_addr,
    input  logic          sys_we,
    input  logic [DW-1:0] sys_wdata,
    output logic [DW-1:0] sys_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          done,
    output logic [1:0]    result
);
    localparam int DEPTH = 1 << AW;
    localparam int NORMAL = DEPTH - SPARES;
    localparam logic [AW-1:0] NORM_A = AW'(NORMAL);

    phase_t        phase;
    logic          retest_bad;
    logic          eng_start, eng_we, eng_fail, eng_done;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_wdata;
    logic          fs_any, fs_ovf;
    logic          hit_eng, hit_sys;
    logic [AW-1:0] spare_eng, spare_sys;
    logic          store_clear, store_rec;

    assign eng_start   = (phase == PH_IDLE && test_mode)
                      || (phase == PH_TEST && eng_done && fs_any && !fs_ovf);
    assign store_clear = (phase == PH_IDLE) && test_mode;
    assign store_rec   = eng_fail && (phase == PH_TEST);

    sr_march_engine #(.AW(AW), .DW(DW), .NORMAL(NORMAL)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .rdata (ram_rdata),
        .addr  (eng_addr),
        .we    (eng_we),
        .wdata (eng_wdata),
        .fail  (eng_fail),
        .done  (eng_done)
    );

    sr_fault_store #(.AW(AW), .SPARES(SPARES), .NORMAL(NORMAL)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (store_clear),
        .rec_en    (store_rec),
        .rec_addr  (eng_addr),
        .a_addr    (eng_addr),
        .a_hit     (hit_eng),
        .a_spare   (spare_eng),
        .b_addr    (sys_addr),
        .b_hit     (hit_sys),
        .b_spare   (spare_sys),
        .any_fault (fs_any),
        .overflow  (fs_ovf)
    );

    // RAM input multiplexer
    always_comb begin
        if (test_mode) begin
            ram_addr  = (phase == PH_RETEST && hit_eng) ? spare_eng : eng_addr;
            ram_we    = eng_we;
            ram_wdata = eng_wdata;
        end else begin
            ram_addr  = (repair_en && hit_sys) ? spare_sys : sys_addr;
            ram_we    = sys_we && !(repair_en && sys_addr >= NORM_A);
            ram_wdata = sys_wdata;
        end
    end

    assign sys_rdata = ram_rdata;
    assign done      = (phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            result     <= RES_CLEAN;
            retest_bad <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (test_mode) phase <= PH_TEST;
                end
                PH_TEST: begin
                    if (eng_done) begin
                        if (!fs_any) begin
                            phase  <= PH_DONE;
                            result <= RES_CLEAN;
                        end else if (fs_ovf) begin
                            phase  <= PH_DONE;
                            result <= RES_OVFL;
                        end else begin
                            phase      <= PH_RETEST;
                            retest_bad <= 1'b0;
                        end
                    end
                end
                PH_RETEST: begin
                    if (eng_fail) retest_bad <= 1'b1;
                    if (eng_done) begin
                        phase  <= PH_DONE;
                        result <= retest_bad ? RES_FAIL : RES_PASS;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sr_checker.sv
module sr_checker
    import srp_pkg::*;
#(
    parameter int AW     = 6,
    parameter int NORMAL = 60
) (
    input logic          clk,
    input logic          rst_n,
    input logic          test_mode,
    input logic          repair_en,
    input logic [AW-1:0] sys_addr,
    input logic          sys_we,
    input logic [AW-1:0] ram_addr,
    input logic          ram_we,
    input logic          done,
    input logic [1:0]    result,
    input phase_t        phase
);
    localparam logic [AW-1:0] NORM_A = AW'(NORMAL);

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R11
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(result)); // R11
    AST_TEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TEST && test_mode) |-> (ram_addr < NORM_A)); // R2
    AST_SPARE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && repair_en && sys_addr >= NORM_A) |-> !ram_we); // R10
    AST_DIRECT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !repair_en) |-> (ram_addr == sys_addr && ram_we == sys_we)); // R9

endmodule

bind selfrepair_top sr_checker #(.AW(AW), .NORMAL(NORMAL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .repair_en (repair_en),
    .sys_addr  (sys_addr),
    .sys_we    (sys_we),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .done      (done),
    .result    (result),
    .phase     (phase)
);

// File: tb/tb_selfrepair_top.sv
module tb_selfrepair_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int DEPTH = 64;

    typedef struct packed {
        logic [63:0] s0;
        logic [63:0] s1;
        logic [1:0]  res;
    } scen_t;

    // stuck words, expected result code
    localparam scen_t SCEN [5] = '{
        '{64'd0, 64'd0, 2'b00},                                         // R3
        '{64'd1 << 17, 64'd1 << 42, 2'b10},                             // R4
        '{(64'd1 << 3) | (64'd1 << 9) | (64'd1 << 20) | (64'd1 << 59),
          64'd0, 2'b10},                                                // R7 (59 = last tested)
        '{64'h3E, 64'd0, 2'b01},                                        // R5
        '{64'd1 << 5, 64'd1 << 60, 2'b11}                               // R6
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0, repair_en = 1'b0;
    logic [AW-1:0] sys_addr = '0;
    logic          sys_we = 1'b0;
    logic [DW-1:0] sys_wdata = '0;
    logic [DW-1:0] sys_rdata, ram_wdata, ram_rdata;
    logic [AW-1:0] ram_addr;
    logic          ram_we, done;
    logic [1:0]    result;
    logic [DEPTH-1:0] sa0 = '0, sa1 = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    selfrepair_top #(.AW(AW), .DW(DW), .SPARES(4)) dut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .repair_en(repair_en),
        .sys_addr(sys_addr), .sys_we(sys_we), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .done(done), .result(result)
    );

    sr_ram_model #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
        .sa0_mask(sa0), .sa1_mask(sa1), .rdata(ram_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_flow(input logic [63:0] m0, input logic [63:0] m1);
        @(negedge clk);
        rst_n = 1'b0; test_mode = 1'b0; repair_en = 1'b0; sys_we = 1'b0;
        sa0 = m0; sa1 = m1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; test_mode = 1'b1;
        for (int c = 0; c < 3000 && !done; c++) @(negedge clk);
        test_mode = 1'b0;
    endtask

    task automatic sys_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        sys_addr = a; sys_wdata = d; sys_we = 1'b1;
        @(negedge clk);
        sys_we = 1'b0;
    endtask

    task automatic sys_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        sys_addr = a;
        #1 d = sys_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic [1:0]    held;

        // R1: reset state and idle without test mode
        repeat (2) @(negedge clk);
        check("R1 done in reset", 64'(done), 64'd0);
        check("R1 result in reset", 64'(result), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle done", 64'(done), 64'd0);
        check("R1 idle result", 64'(result), 64'd0);

        for (int i = 0; i < 5; i++) begin
            run_flow(SCEN[i].s0, SCEN[i].s1);
            check($sformatf("R2 flow %0d done", i), 64'(done), 64'd1);
            check($sformatf("R3-R7 flow %0d result", i), 64'(result), 64'(SCEN[i].res));
        end

        // R11: outcome held while inputs move
        held = result;
        test_mode = 1'b1;
        repeat (20) @(negedge clk);
        test_mode = 1'b0;
        check("R11 done held", 64'(done), 64'd1);
        check("R11 result held", 64'(result), 64'(held));

        // repaired part: 42 found first -> word 60, 17 -> word 61
        run_flow(64'd1 << 17, 64'd1 << 42);
        check("R4 repaired", 64'(result), 64'b10);
        repair_en = 1'b1;
        sys_write(6'd17, 32'hA5A5_5A5A);
        sys_read(6'd17, rd);
        check("R8 word 17 remapped", 64'(rd), 64'hA5A5_5A5A);
        sys_write(6'd42, 32'h0000_1234);
        sys_read(6'd42, rd);
        check("R8 word 42 remapped", 64'(rd), 64'h0000_1234);

        repair_en = 1'b0;
        sys_read(6'd61, rd);
        check("R8 spare 61 holds 17", 64'(rd), 64'hA5A5_5A5A);
        sys_read(6'd60, rd);
        check("R8 spare 60 holds 42", 64'(rd), 64'h0000_1234);
        sys_write(6'd17, 32'hFFFF_FFFF);
        sys_read(6'd17, rd);
        check("R9 faulty word direct", 64'(rd), 64'd0);
        sys_write(6'd62, 32'hC0DE_0001);
        sys_read(6'd62, rd);
        check("R9 spare direct", 64'(rd), 64'hC0DE_0001);

        repair_en = 1'b1;
        sys_write(6'd62, 32'hBAD0_BAD0);
        repair_en = 1'b0;
        sys_read(6'd62, rd);
        check("R10 spare write blocked", 64'(rd), 64'hC0DE_0001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule